// File: doc/BRIEF.md
# Operand Forwarding and Load-Use Stall Unit

This block sits beside a five-stage in-order integer pipeline and decides, every cycle, where the two ALU operands of the instruction in execute come from. An operand can come from the register file, from the result waiting in the execute/memory pipeline register, or from the result waiting in the memory/writeback pipeline register. A source register is only forwarded when the producing stage will really write a register, and only when that destination is not register 0. If both later stages hold a match, the younger one wins. The store-data operand is taken from the second source, so it is forwarded by exactly the same rules as any ALU operand.

The unit also detects the one hazard that forwarding cannot cover. This is a load in execute whose destination is a source that the instruction in decode really reads. In that case it raises three strobes together. They freeze the program counter and the fetch/decode register, and they replace the control fields of the instruction entering execute with zeros. The dependent instruction then decodes again in the next cycle. Writeback-to-decode hazards are not handled here, because the register file writes before it reads within a cycle. The block is purely combinational.

Top module: `hazard_fwd_unit`

## Requirements
- R1: `fwdA` reads 2'b10 (execute/memory result) when the execute/memory stage writes a register, its destination is not 0, and that destination equals `exRs`.
- R2: `fwdA` reads 2'b01 (memory/writeback result) when the memory/writeback stage qualifies the same way against `exRs` and the execute/memory stage does not.
- R3: When both stages qualify for the same operand, the select is 2'b10, because the execute/memory result is the newer one.
- R4: A destination of register 0 never produces a forward select or a stall.
- R5: A stage whose register-write bit is clear never causes a forward, whatever its destination fields hold.
- R6: The destination of a producing stage is its rt field when its load bit is set, and its rd field otherwise.
- R7: `fwdB` follows R1 to R6 with `exRt` in place of `exRs`. This covers the store-data operand.
- R8: `holdPc`, `holdIfId` and `bubbleIdEx` all read 1 when `idExMemRead` is 1, `exRt` is not 0, and either `decReadsRs` is set with `decRs` equal to `exRt`, or `decReadsRt` is set with `decRt` equal to `exRt`.
- R9: The three stall strobes read 0 whenever the instruction in execute is not a load, or when a matching decode field is marked as not read.
- R10: A select reads 2'b00 (register file) when no stage qualifies, and the code 2'b11 never appears.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| decRs | input | REG_W | First source register of the instruction in decode |
| decRt | input | REG_W | Second source register of the instruction in decode |
| decReadsRs | input | 1 | Decode instruction really reads decRs |
| decReadsRt | input | 1 | Decode instruction really reads decRt |
| exRs | input | REG_W | First source register of the instruction in execute |
| exRt | input | REG_W | Second source of the instruction in execute (also a load's destination) |
| idExMemRead | input | 1 | Instruction in execute is a load |
| exMemRegWrite | input | 1 | Execute/memory stage writes a register |
| exMemIsLoad | input | 1 | Execute/memory stage holds a load (destination is rt) |
| exMemRd | input | REG_W | rd field held in execute/memory |
| exMemRt | input | REG_W | rt field held in execute/memory |
| memWbRegWrite | input | 1 | Memory/writeback stage writes a register |
| memWbIsLoad | input | 1 | Memory/writeback stage holds a load (destination is rt) |
| memWbRd | input | REG_W | rd field held in memory/writeback |
| memWbRt | input | REG_W | rt field held in memory/writeback |
| fwdA | output | 2 | Source select for ALU operand A |
| fwdB | output | 2 | Source select for ALU operand B / store data |
| holdPc | output | 1 | Keep the program counter |
| holdIfId | output | 1 | Keep the fetch/decode register |
| bubbleIdEx | output | 1 | Zero the control fields entering execute |

## Verification
The embedded checks assume that the control bits arrive as clean 0 or 1 values. They also assume that the load bit of a stage is only meaningful when its register-write bit is set. They do not assume any relation between the register numbers of different stages. The stimulus therefore sets every register field freely, including many deliberate collisions and zeros. A load bit is only raised together with its write bit in the directed cases. The random phase sweeps all combinations, and the bench model treats them by the rules alone.

// File: rtl/hazard_pkg.sv
package hazard_pkg;

  typedef enum logic [1:0] {
    OPND_REGFILE = 2'b00,
    OPND_MEMWB   = 2'b01,
    OPND_EXMEM   = 2'b10
  } opndSrc_t;

  // strobes from the qualifying control to the comparing datapath
  typedef struct packed {
    logic exMemLive;
    logic memWbLive;
    logic loadLive;
  } hazStrobe_t;

  typedef struct packed {
    logic holdPc;
    logic holdIfId;
    logic bubbleIdEx;
  } stallStrobe_t;

endpackage

// File: rtl/hazard_ctrl.sv
module hazard_ctrl
  import hazard_pkg::*;
#(
  parameter int REG_W = 3
) (
  input  logic             exMemRegWrite,
  input  logic             exMemIsLoad,
  input  logic [REG_W-1:0] exMemRd,
  input  logic [REG_W-1:0] exMemRt,
  input  logic             memWbRegWrite,
  input  logic             memWbIsLoad,
  input  logic [REG_W-1:0] memWbRd,
  input  logic [REG_W-1:0] memWbRt,
  input  logic             idExMemRead,
  input  logic [REG_W-1:0] exRt,
  output logic [REG_W-1:0] exMemDest,
  output logic [REG_W-1:0] memWbDest,
  output hazStrobe_t       strobe
);

  localparam int NUM_PROD = 2;
  localparam logic [REG_W-1:0] ZERO_REG = '0;

  logic             prodWrite [NUM_PROD];
  logic             prodLoad  [NUM_PROD];
  logic [REG_W-1:0] prodRd    [NUM_PROD];
  logic [REG_W-1:0] prodRt    [NUM_PROD];
  logic [REG_W-1:0] prodDest  [NUM_PROD];
  logic             prodLive  [NUM_PROD];

  assign prodWrite[0] = exMemRegWrite;
  assign prodLoad[0]  = exMemIsLoad;
  assign prodRd[0]    = exMemRd;
  assign prodRt[0]    = exMemRt;
  assign prodWrite[1] = memWbRegWrite;
  assign prodLoad[1]  = memWbIsLoad;
  assign prodRd[1]    = memWbRd;
  assign prodRt[1]    = memWbRt;

  // index 0 is the younger producer
  for (genvar p = 0; p < NUM_PROD; p++) begin : g_prod
    // R6: loads write rt, everything else writes rd
    assign prodDest[p] = prodLoad[p] ? prodRt[p] : prodRd[p];
    // R4, R5: only a real write to a nonzero register counts
    assign prodLive[p] = prodWrite[p] && (prodDest[p] != ZERO_REG);
  end

  assign exMemDest        = prodDest[0];
  assign memWbDest        = prodDest[1];
  assign strobe.exMemLive = prodLive[0];
  assign strobe.memWbLive = prodLive[1];
  assign strobe.loadLive  = idExMemRead && (exRt != ZERO_REG);

  always_comb begin
    a_r5_no_live_without_write: assert (!(strobe.exMemLive && !exMemRegWrite)
                                        && !(strobe.memWbLive && !memWbRegWrite))
      else $error("R5: producer live without register write");
  end

endmodule

// File: rtl/opnd_select.sv
module opnd_select
  import hazard_pkg::*;
#(
  parameter int REG_W = 3
) (
  input  logic [REG_W-1:0] srcReg,
  input  logic             exMemLive,
  input  logic [REG_W-1:0] exMemDest,
  input  logic             memWbLive,
  input  logic [REG_W-1:0] memWbDest,
  output opndSrc_t         sel
);

  logic hitExMem;
  logic hitMemWb;

  assign hitExMem = exMemLive && (exMemDest == srcReg);
  assign hitMemWb = memWbLive && (memWbDest == srcReg);

  // R3: the younger producer takes precedence
  always_comb begin
    if (hitExMem)      sel = OPND_EXMEM;
    else if (hitMemWb) sel = OPND_MEMWB;
    else               sel = OPND_REGFILE;
  end

endmodule

// File: rtl/fwd_datapath.sv
module fwd_datapath
  import hazard_pkg::*;
#(
  parameter int REG_W = 3
) (
  input  hazStrobe_t       strobe,
  input  logic [REG_W-1:0] exMemDest,
  input  logic [REG_W-1:0] memWbDest,
  input  logic [REG_W-1:0] exRs,
  input  logic [REG_W-1:0] exRt,
  input  logic [REG_W-1:0] decRs,
  input  logic [REG_W-1:0] decRt,
  input  logic             decReadsRs,
  input  logic             decReadsRt,
  output opndSrc_t         fwdA,
  output opndSrc_t         fwdB,
  output stallStrobe_t     stall
);

  localparam int NUM_OPND = 2;

  logic [REG_W-1:0] exSrc   [NUM_OPND];
  logic [REG_W-1:0] decSrc  [NUM_OPND];
  logic             decUsed [NUM_OPND];
  opndSrc_t         opndSel [NUM_OPND];
  logic [NUM_OPND-1:0] loadHit;

  assign exSrc[0]   = exRs;
  assign exSrc[1]   = exRt;
  assign decSrc[0]  = decRs;
  assign decSrc[1]  = decRt;
  assign decUsed[0] = decReadsRs;
  assign decUsed[1] = decReadsRt;

  for (genvar k = 0; k < NUM_OPND; k++) begin : g_opnd
    opnd_select #(.REG_W(REG_W)) i_sel (
      .srcReg    (exSrc[k]),
      .exMemLive (strobe.exMemLive),
      .exMemDest (exMemDest),
      .memWbLive (strobe.memWbLive),
      .memWbDest (memWbDest),
      .sel       (opndSel[k])
    );
    // R8, R9: the load destination is the rt of the execute instruction
    assign loadHit[k] = strobe.loadLive && decUsed[k] && (decSrc[k] == exRt);
  end

  assign fwdA = opndSel[0];
  assign fwdB = opndSel[1];

  logic stallAny;
  assign stallAny         = |loadHit;
  assign stall.holdPc     = stallAny;
  assign stall.holdIfId   = stallAny;
  assign stall.bubbleIdEx = stallAny;

  always_comb begin
    a_r1_exmem_needs_live: assert (!(fwdA == OPND_EXMEM || fwdB == OPND_EXMEM) || strobe.exMemLive)
      else $error("R1: execute/memory forward without a live producer");
    a_r2_memwb_needs_live: assert (!(fwdA == OPND_MEMWB || fwdB == OPND_MEMWB) || strobe.memWbLive)
      else $error("R2: memory/writeback forward without a live producer");
    a_r9_stall_needs_load: assert (!stallAny || strobe.loadLive)
      else $error("R9: stall without a load in execute");
  end

endmodule

// File: rtl/hazard_fwd_unit.sv
module hazard_fwd_unit
  import hazard_pkg::*;
#(
  parameter int REG_W = 3
) (
  input  logic [REG_W-1:0] decRs,
  input  logic [REG_W-1:0] decRt,
  input  logic             decReadsRs,
  input  logic             decReadsRt,
  input  logic [REG_W-1:0] exRs,
  input  logic [REG_W-1:0] exRt,
  input  logic             idExMemRead,
  input  logic             exMemRegWrite,
  input  logic             exMemIsLoad,
  input  logic [REG_W-1:0] exMemRd,
  input  logic [REG_W-1:0] exMemRt,
  input  logic             memWbRegWrite,
  input  logic             memWbIsLoad,
  input  logic [REG_W-1:0] memWbRd,
  input  logic [REG_W-1:0] memWbRt,
  output logic [1:0]       fwdA,
  output logic [1:0]       fwdB,
  output logic             holdPc,
  output logic             holdIfId,
  output logic             bubbleIdEx
);

  hazStrobe_t       strobe;
  stallStrobe_t     stall;
  opndSrc_t         selA;
  opndSrc_t         selB;
  logic [REG_W-1:0] exMemDest;
  logic [REG_W-1:0] memWbDest;

  hazard_ctrl #(.REG_W(REG_W)) i_ctrl (
    .exMemRegWrite (exMemRegWrite),
    .exMemIsLoad   (exMemIsLoad),
    .exMemRd       (exMemRd),
    .exMemRt       (exMemRt),
    .memWbRegWrite (memWbRegWrite),
    .memWbIsLoad   (memWbIsLoad),
    .memWbRd       (memWbRd),
    .memWbRt       (memWbRt),
    .idExMemRead   (idExMemRead),
    .exRt          (exRt),
    .exMemDest     (exMemDest),
    .memWbDest     (memWbDest),
    .strobe        (strobe)
  );

  fwd_datapath #(.REG_W(REG_W)) i_dp (
    .strobe     (strobe),
    .exMemDest  (exMemDest),
    .memWbDest  (memWbDest),
    .exRs       (exRs),
    .exRt       (exRt),
    .decRs      (decRs),
    .decRt      (decRt),
    .decReadsRs (decReadsRs),
    .decReadsRt (decReadsRt),
    .fwdA       (selA),
    .fwdB       (selB),
    .stall      (stall)
  );

  assign fwdA       = selA;
  assign fwdB       = selB;
  assign holdPc     = stall.holdPc;
  assign holdIfId   = stall.holdIfId;
  assign bubbleIdEx = stall.bubbleIdEx;

  always_comb begin
    a_r10_no_code_11: assert (fwdA != 2'b11 && fwdB != 2'b11)
      else $error("R10: reserved select code");
    a_r4_zero_never_stalls: assert (!holdPc || exRt != '0)
      else $error("R4: stall on register 0");
    a_r5_write_gates_forward: assert ((fwdA != 2'b10 && fwdB != 2'b10) || exMemRegWrite)
      else $error("R5: forward from a stage that does not write");
    a_r8_strobes_agree: assert (holdPc == holdIfId && holdIfId == bubbleIdEx)
      else $error("R8: stall strobes disagree");
  end

endmodule

// File: tb/test_hazard_fwd_unit.sv
module test_hazard_fwd_unit;

  localparam int REG_W = 3;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #10 clk = ~clk;

  logic [REG_W-1:0] decRs, decRt, exRs, exRt, exMemRd, exMemRt, memWbRd, memWbRt;
  logic decReadsRs, decReadsRt, idExMemRead;
  logic exMemRegWrite, exMemIsLoad, memWbRegWrite, memWbIsLoad;
  logic [1:0] fwdA, fwdB;
  logic holdPc, holdIfId, bubbleIdEx;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  hazard_fwd_unit #(.REG_W(REG_W)) i_hazard_fwd_unit (
    .decRs(decRs), .decRt(decRt), .decReadsRs(decReadsRs), .decReadsRt(decReadsRt),
    .exRs(exRs), .exRt(exRt), .idExMemRead(idExMemRead),
    .exMemRegWrite(exMemRegWrite), .exMemIsLoad(exMemIsLoad),
    .exMemRd(exMemRd), .exMemRt(exMemRt),
    .memWbRegWrite(memWbRegWrite), .memWbIsLoad(memWbIsLoad),
    .memWbRd(memWbRd), .memWbRt(memWbRt),
    .fwdA(fwdA), .fwdB(fwdB), .holdPc(holdPc), .holdIfId(holdIfId), .bubbleIdEx(bubbleIdEx)
  );

  // behavioural model: scan a list of producers, youngest first
  function automatic int modelSel(int src);
    int dest[$];
    int code[$];
    int d;
    if (exMemRegWrite) begin
      d = exMemIsLoad ? int'(exMemRt) : int'(exMemRd);
      dest.push_back(d); code.push_back(2);
    end
    if (memWbRegWrite) begin
      d = memWbIsLoad ? int'(memWbRt) : int'(memWbRd);
      dest.push_back(d); code.push_back(1);
    end
    foreach (dest[i]) if (dest[i] != 0 && dest[i] == src) return code[i];
    return 0;
  endfunction

  function automatic int modelStall();
    if (!idExMemRead || exRt == 0) return 0;
    if (decReadsRs && decRs == exRt) return 1;
    if (decReadsRt && decRt == exRt) return 1;
    return 0;
  endfunction

  task automatic check(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic clearIns();
    decRs = '0; decRt = '0; exRs = '0; exRt = '0;
    exMemRd = '0; exMemRt = '0; memWbRd = '0; memWbRt = '0;
    decReadsRs = 1'b0; decReadsRt = 1'b0; idExMemRead = 1'b0;
    exMemRegWrite = 1'b0; exMemIsLoad = 1'b0; memWbRegWrite = 1'b0; memWbIsLoad = 1'b0;
  endtask

  // outputs compared against the model on every clock, mid-cycle
  task automatic stepCheck(string tag);
    @(posedge clk);
    #5;
    check({tag, " fwdA"}, int'(fwdA), modelSel(int'(exRs)));
    check({tag, " fwdB"}, int'(fwdB), modelSel(int'(exRt)));
    check({tag, " holdPc"}, int'(holdPc), modelStall());
    check({tag, " holdIfId"}, int'(holdIfId), modelStall());
    check({tag, " bubbleIdEx"}, int'(bubbleIdEx), modelStall());
  endtask

  task automatic finish();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish();
  end

  initial begin
    clearIns();
    repeat (3) @(posedge clk);
    rstN = 1'b1;
    // reset/idle state: all zero
    @(posedge clk); #5;
    check("R10 idle fwdA", int'(fwdA), 0);
    check("R10 idle fwdB", int'(fwdB), 0);
    check("R9 idle stall", int'(holdPc), 0);

    // R1: execute/memory forward to A
    clearIns(); exMemRegWrite = 1; exMemRd = 3; exRs = 3; exRt = 4;
    @(posedge clk); #5;
    check("R1 exmem to A", int'(fwdA), 2);
    check("R1 B untouched", int'(fwdB), 0);

    // R2: memory/writeback forward to A
    clearIns(); memWbRegWrite = 1; memWbRd = 5; exRs = 5;
    @(posedge clk); #5;
    check("R2 memwb to A", int'(fwdA), 1);

    // R3: both match, younger wins
    clearIns(); exMemRegWrite = 1; exMemRd = 2; memWbRegWrite = 1; memWbRd = 2; exRs = 2; exRt = 2;
    @(posedge clk); #5;
    check("R3 priority A", int'(fwdA), 2);
    check("R3 priority B", int'(fwdB), 2);

    // R4: register 0 destinations
    clearIns(); exMemRegWrite = 1; memWbRegWrite = 1; idExMemRead = 1;
    decReadsRs = 1; decReadsRt = 1;
    @(posedge clk); #5;
    check("R4 zero no fwd A", int'(fwdA), 0);
    check("R4 zero no fwd B", int'(fwdB), 0);
    check("R4 zero no stall", int'(holdPc), 0);

    // R5: write bit clear
    clearIns(); exMemRd = 6; memWbRd = 6; exRs = 6; exRt = 6;
    @(posedge clk); #5;
    check("R5 no write A", int'(fwdA), 0);
    check("R5 no write B", int'(fwdB), 0);

    // R6: load takes rt, not rd
    clearIns(); exMemRegWrite = 1; exMemIsLoad = 1; exMemRt = 1; exMemRd = 7; exRs = 7; exRt = 1;
    @(posedge clk); #5;
    check("R6 load rd ignored", int'(fwdA), 0);
    check("R6 load rt used", int'(fwdB), 2);
    clearIns(); memWbRegWrite = 1; memWbIsLoad = 0; memWbRt = 4; memWbRd = 3; exRs = 4; exRt = 3;
    @(posedge clk); #5;
    check("R6 rtype rt ignored", int'(fwdA), 0);
    check("R7 store data memwb", int'(fwdB), 1);

    // R8: load-use via rs and via rt
    clearIns(); idExMemRead = 1; exRt = 5; decRs = 5; decReadsRs = 1;
    @(posedge clk); #5;
    check("R8 stall rs holdPc", int'(holdPc), 1);
    check("R8 stall rs holdIfId", int'(holdIfId), 1);
    check("R8 stall rs bubble", int'(bubbleIdEx), 1);
    clearIns(); idExMemRead = 1; exRt = 2; decRt = 2; decReadsRt = 1;
    @(posedge clk); #5;
    check("R8 stall rt", int'(bubbleIdEx), 1);

    // R9: no stall without load, or unread field
    clearIns(); exRt = 5; decRs = 5; decReadsRs = 1;
    @(posedge clk); #5;
    check("R9 not a load", int'(holdPc), 0);
    clearIns(); idExMemRead = 1; exRt = 5; decRt = 5; decReadsRt = 0; decReadsRs = 1; decRs = 1;
    @(posedge clk); #5;
    check("R9 unread rt", int'(holdPc), 0);

    // random sweep compared against the model each clock (R1..R10)
    for (int n = 0; n < 3000; n++) begin
      decRs = REG_W'($urandom); decRt = REG_W'($urandom);
      exRs = REG_W'($urandom); exRt = REG_W'($urandom);
      exMemRd = REG_W'($urandom); exMemRt = REG_W'($urandom);
      memWbRd = REG_W'($urandom); memWbRt = REG_W'($urandom);
      decReadsRs = 1'($urandom); decReadsRt = 1'($urandom);
      idExMemRead = 1'($urandom); exMemRegWrite = 1'($urandom);
      exMemIsLoad = 1'($urandom); memWbRegWrite = 1'($urandom);
      memWbIsLoad = 1'($urandom);
      stepCheck("R1-R10 sweep: R1 R2 R3 R4 R5 R6 R7 R8 R9 R10");
    end
    finish();
  end

endmodule